// File: doc/BRIEF.md
# Windowed DRAM Power Limiter

This block holds the DRAM domain to two average-power caps. Per-channel energy increments arrive as a stream, are summed into time slots one tick long (a tick is 1/1024 s), and the slot totals are kept in a short history. For each cap, a running sum covers the most recent slots of that cap's window. When an enabled cap's window energy exceeds cap × window, the block raises a throttle request. A per-channel floor keeps a channel from being throttled while its own recent power is at or below that floor. A wrapping counter adds up throttled channel-ticks.

Energy is in units of 1/8 W × 1/1024 s, so a slot total equals the average power over that tick in 0.125 W steps. Caps and floors are in 0.125 W steps as well. One configuration word holds both caps and a lock bit. Software writes the word as a whole, and reset is the only thing that clears the lock.

The energy input is a valid/ready stream. `e_ready` is high on every cycle except one in which a configuration write is accepted. A beat is taken only when `e_valid` and `e_ready` are both high. The source must hold a refused beat and offer it again. A beat taken in a tick cycle belongs to the slot that this tick closes.

Top module: `dram_pwr_limiter`

## Requirements
- R1: Window length in slots is floor((4 + F) × 2^E / 4), where F is the 2-bit fraction field and E is the 5-bit exponent field. The result is clamped to the range 1 to HIST.
- R2: Each cap is a 14-bit value in 11.3 format (0 to 2047.875 W). A cap is exceeded only when the window energy is strictly greater than cap × window length. Equal energy does not throttle.
- R3: There are two caps, each with its own enable bit, cap value and window. `throttle` is the OR of the enabled caps that are exceeded, and a disabled cap has no effect.
- R4: The configuration word is 45 bits. Cap 0 occupies bits 21:0 and cap 1 occupies bits 43:22, each with value [13:0], fraction [15:14], exponent [20:16] and enable [21]. Bit 44 is the lock. While the lock reads 1, writes are ignored, `cfg_rdata` does not change and `e_ready` stays high.
- R5: `chan_thr[c]` is high only when `throttle` is high and channel c's energy in the most recently closed slot is greater than its 8-bit floor in 5.3 format. The floor for channel c is `floor_q[8c+7:8c]`.
- R6: At each tick, `thr_dur` grows by the number of channels whose `chan_thr` was high. It wraps modulo 2^DUR_W.
- R7: `throttle` changes only in the cycle after a tick or after an accepted write. At any other time it holds.
- R8: `e_ready` is low exactly in a cycle with an accepted configuration write, and the beat offered in that cycle is not taken. A beat taken in a tick cycle counts in the slot that the tick closes.
- R9: An accepted write clears the history, the running sums, the open slot and the last-slot values, so `throttle` and `chan_thr` read 0 in the following cycle.
- R10: After reset, `throttle`, `chan_thr`, `thr_dur` and `cfg_rdata` read 0, and `e_ready` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe every 1/1024 s |
| e_valid | input | 1 | Energy beat valid |
| e_ready | output | 1 | Energy beat accepted when high with e_valid |
| e_chan | input | $clog2(NCH) | Channel of the beat |
| e_amt | input | ESW | Energy of the beat |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 45 | Configuration word to write |
| cfg_rdata | output | 45 | Current configuration word |
| floor_q | input | NCH*8 | Per-channel power floors, 5.3 W |
| throttle | output | 1 | Throttle request |
| chan_thr | output | NCH | Per-channel throttle after floor |
| thr_dur | output | DUR_W | Throttled channel-tick count |

## Verification
The bench builds the block with two channels, an eight-slot history and a 6-bit duration counter. With only eight slots, exponents 0 to 4 combined with every fraction cover both exact windows and clamped windows. Every fraction/exponent pair is swept against a slot pattern whose averages straddle the cap, and the model works out each expected sum directly. With a 6-bit counter, wrap-around comes within a few dozen ticks. The small energy width keeps slot sums small enough that no window can overflow.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  localparam int PWR_W   = 14;
  localparam int FRAC_W  = 2;
  localparam int EXP_W   = 5;
  localparam int FLOOR_W = 8;

  typedef struct packed {
    logic              en;
    logic [EXP_W-1:0]  wexp;
    logic [FRAC_W-1:0] wfrac;
    logic [PWR_W-1:0]  pwr;
  } lim_cfg_t;

  localparam int LIM_CFG_W = $bits(lim_cfg_t);
endpackage

// File: rtl/dpl_cfg_reg.sv
module dpl_cfg_reg
  import dpl_pkg::*;
#(
  parameter int NLIM = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [NLIM*LIM_CFG_W:0]       wdata,
  output logic [NLIM*LIM_CFG_W:0]       rdata,
  output lim_cfg_t [NLIM-1:0]           lim_o,
  output logic                          wr_acc
);
  localparam int REG_W = NLIM*LIM_CFG_W + 1;

  logic [REG_W-1:0] reg_q;

  // the lock is the top bit; once set only reset clears it
  assign wr_acc = we && !reg_q[REG_W-1];
  assign rdata  = reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_q <= '0;
    else if (wr_acc) reg_q <= wdata;
  end

  for (genvar k = 0; k < NLIM; k++) begin : g_lim
    assign lim_o[k] = lim_cfg_t'(reg_q[k*LIM_CFG_W +: LIM_CFG_W]);
  end
endmodule

// File: rtl/dpl_slot_acc.sv
module dpl_slot_acc #(
  parameter int NCH    = 2,
  parameter int ESW    = 16,
  parameter int SLOT_W = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          tick,
  input  logic                          beat_v,
  input  logic [$clog2(NCH)-1:0]        beat_ch,
  input  logic [ESW-1:0]                beat_amt,
  output logic [SLOT_W-1:0]             slot_total,
  output logic [NCH-1:0][SLOT_W-1:0]    chan_last
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0][SLOT_W-1:0] acc_q;
  logic [NCH-1:0][SLOT_W-1:0] acc_nxt;

  // open-slot value per channel including the beat of this cycle
  always_comb begin
    slot_total = '0;
    for (int c = 0; c < NCH; c++) begin
      acc_nxt[c] = acc_q[c];
      if (beat_v && beat_ch == CHW'(c))
        acc_nxt[c] = acc_q[c] + SLOT_W'(beat_amt);
      slot_total = slot_total + acc_nxt[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q     <= '0;
      chan_last <= '0;
    end else if (tick) begin
      chan_last <= acc_nxt;
      acc_q     <= '0;
    end else begin
      acc_q     <= acc_nxt;
    end
  end
endmodule

// File: rtl/dpl_history.sv
module dpl_history #(
  parameter int HIST   = 64,
  parameter int SLOT_W = 24,
  parameter int SUM_W  = 32,
  parameter int NLIM   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 tick,
  input  logic [SLOT_W-1:0]                    slot_in,
  input  logic [NLIM-1:0][$clog2(HIST)-1:0]    wlen_mod,
  output logic [NLIM-1:0][SUM_W-1:0]           sum_q
);
  localparam int HL = $clog2(HIST);

  logic [HIST-1:0][SLOT_W-1:0] ring_q;
  logic [HL-1:0]               wptr_q;
  logic [NLIM-1:0][SUM_W-1:0]  sum_nxt;

  // each window drops the slot that falls out of it as the new one enters;
  // a full-length window (wlen_mod == 0) drops the entry being overwritten
  for (genvar k = 0; k < NLIM; k++) begin : g_win
    logic [HL-1:0] rd_idx;
    assign rd_idx     = wptr_q - wlen_mod[k];
    assign sum_nxt[k] = sum_q[k] + SUM_W'(slot_in) - SUM_W'(ring_q[rd_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ring_q <= '0;
      wptr_q <= '0;
      sum_q  <= '0;
    end else if (tick) begin
      ring_q[wptr_q] <= slot_in;
      wptr_q         <= wptr_q + 1'b1;
      sum_q          <= sum_nxt;
    end
  end
endmodule

// File: rtl/dpl_limit_cmp.sv
module dpl_limit_cmp
  import dpl_pkg::*;
#(
  parameter int HIST  = 64,
  parameter int SUM_W = 32
) (
  input  lim_cfg_t                   cfg,
  input  logic [SUM_W-1:0]           sum,
  output logic [$clog2(HIST):0]      wlen,
  output logic                       over
);
  localparam int HL = $clog2(HIST);
  localparam int PW = PWR_W + HL + 1;
  localparam int CW = (SUM_W > PW) ? SUM_W : PW;

  logic [HL+2:0] raw;
  logic [PW-1:0] budget;

  // (4 + frac) << exp, then /4, clamped to the history depth
  always_comb begin
    raw = {{HL{1'b0}}, 1'b1, cfg.wfrac} << cfg.wexp;
    if (int'(cfg.wexp) > HL)
      wlen = (HL+1)'(HIST);
    else if (raw[HL+2:2] > (HL+1)'(HIST))
      wlen = (HL+1)'(HIST);
    else
      wlen = raw[HL+2:2];
  end

  assign budget = PW'(cfg.pwr) * PW'(wlen);
  assign over   = cfg.en && (CW'(sum) > CW'(budget));
endmodule

// File: rtl/dram_pwr_limiter.sv
module dram_pwr_limiter
  import dpl_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int NLIM   = 2,
  parameter int HIST   = 64,
  parameter int ESW    = 16,
  parameter int SLOT_W = 24,
  parameter int DUR_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        e_valid,
  output logic                        e_ready,
  input  logic [$clog2(NCH)-1:0]      e_chan,
  input  logic [ESW-1:0]              e_amt,
  input  logic                        cfg_we,
  input  logic [NLIM*LIM_CFG_W:0]     cfg_wdata,
  output logic [NLIM*LIM_CFG_W:0]     cfg_rdata,
  input  logic [NCH*FLOOR_W-1:0]      floor_q,
  output logic                        throttle,
  output logic [NCH-1:0]              chan_thr,
  output logic [DUR_W-1:0]            thr_dur
);
  localparam int HL    = $clog2(HIST);
  localparam int SUM_W = SLOT_W + HL + 1;

  lim_cfg_t [NLIM-1:0]            lim;
  logic                           wr_acc;
  logic [SLOT_W-1:0]              slot_total;
  logic [NCH-1:0][SLOT_W-1:0]     chan_last;
  logic [NLIM-1:0][SUM_W-1:0]     sums;
  logic [NLIM-1:0][HL:0]          wlen;
  logic [NLIM-1:0][HL-1:0]        wlen_mod;
  logic [NLIM-1:0]                over;
  logic [DUR_W-1:0]               dur_q;

  assign e_ready = !wr_acc;

  dpl_cfg_reg #(.NLIM(NLIM)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .lim_o(lim), .wr_acc(wr_acc)
  );

  dpl_slot_acc #(.NCH(NCH), .ESW(ESW), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(wr_acc), .tick(tick),
    .beat_v(e_valid && e_ready), .beat_ch(e_chan), .beat_amt(e_amt),
    .slot_total(slot_total), .chan_last(chan_last)
  );

  dpl_history #(.HIST(HIST), .SLOT_W(SLOT_W), .SUM_W(SUM_W), .NLIM(NLIM)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(wr_acc), .tick(tick),
    .slot_in(slot_total), .wlen_mod(wlen_mod), .sum_q(sums)
  );

  for (genvar k = 0; k < NLIM; k++) begin : g_cmp
    dpl_limit_cmp #(.HIST(HIST), .SUM_W(SUM_W)) u_cmp (
      .cfg(lim[k]), .sum(sums[k]), .wlen(wlen[k]), .over(over[k])
    );
    assign wlen_mod[k] = wlen[k][HL-1:0];
  end

  assign throttle = |over;

  // floor: a channel at or under its floor over the last slot is spared
  for (genvar c = 0; c < NCH; c++) begin : g_floor
    assign chan_thr[c] = throttle &&
      (chan_last[c] > SLOT_W'(floor_q[c*FLOOR_W +: FLOOR_W]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    dur_q <= '0;
    else if (tick) dur_q <= dur_q + DUR_W'($countones(chan_thr));
  end

  assign thr_dur = dur_q;
endmodule

// File: rtl/dram_pwr_limiter_chk.sv
module dram_pwr_limiter_chk #(
  parameter int NCH   = 2,
  parameter int REG_W = 45,
  parameter int DUR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             throttle,
  input logic [NCH-1:0]   chan_thr,
  input logic [DUR_W-1:0] thr_dur
);
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_rdata[REG_W-1]) |-> $stable(cfg_rdata));

  // R5
  floor_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_thr) |-> throttle);

  // R6
  dur_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) |-> thr_dur == DUR_W'($past(thr_dur) + DUR_W'($countones($past(chan_thr)))));

  // R6
  dur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(thr_dur));

  // R7
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(cfg_we)) |-> $stable(throttle));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && !cfg_rdata[REG_W-1]) |-> (!throttle && chan_thr == '0));
endmodule

bind dram_pwr_limiter dram_pwr_limiter_chk #(
  .NCH(NCH), .REG_W(NLIM*dpl_pkg::LIM_CFG_W + 1), .DUR_W(DUR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
  .cfg_rdata(cfg_rdata), .throttle(throttle), .chan_thr(chan_thr),
  .thr_dur(thr_dur)
);

// File: tb/dram_pwr_limiter_test.sv
`timescale 1ns/1ps
module dram_pwr_limiter_test;
  localparam int NCH = 2, NLIM = 2, HIST = 8, ESW = 8, SLOT_W = 12, DUR_W = 6;
  localparam int REG_W = 45;

  logic clk = 0, rst_n = 0, tick = 0, e_valid = 0, cfg_we = 0;
  logic e_ready, throttle;
  logic [0:0] e_chan = '0;
  logic [ESW-1:0] e_amt = '0;
  logic [REG_W-1:0] cfg_wdata = '0, cfg_rdata;
  logic [NCH*8-1:0] floor_q = '0;
  logic [NCH-1:0] chan_thr;
  logic [DUR_W-1:0] thr_dur;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model
  int hist[$];
  int macc[2], mlast[2], mfloor[2];
  int men[2], mpwr[2], mx[2], my[2];
  bit mthr, mlock;
  bit [1:0] mchthr;
  int mdur;
  logic [REG_W-1:0] mreg;

  always #2.5 clk = ~clk;

  dram_pwr_limiter #(.NCH(NCH), .NLIM(NLIM), .HIST(HIST), .ESW(ESW),
                     .SLOT_W(SLOT_W), .DUR_W(DUR_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .e_valid(e_valid), .e_ready(e_ready),
    .e_chan(e_chan), .e_amt(e_amt), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .floor_q(floor_q), .throttle(throttle),
    .chan_thr(chan_thr), .thr_dur(thr_dur));

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wl(int x, int y);
    int t;
    if (y > 3) return HIST;
    t = ((4 + x) << y) / 4;
    if (t > HIST) t = HIST;
    return t;
  endfunction

  function automatic void evaluate();
    mthr = 0;
    for (int k = 0; k < 2; k++) begin
      int w = wl(mx[k], my[k]);
      int s = 0;
      for (int j = 0; j < w && j < hist.size(); j++) s += hist[hist.size()-1-j];
      if (men[k] != 0 && s > mpwr[k] * w) mthr = 1;
    end
    for (int c = 0; c < 2; c++) mchthr[c] = mthr && (mlast[c] > mfloor[c]);
  endfunction

  function automatic logic [21:0] lim_word(int en, int p, int x, int y);
    return {en[0], y[4:0], x[1:0], p[13:0]};
  endfunction

  // called at a negedge; ends at the next negedge
  task automatic wr_cfg(logic [REG_W-1:0] d);
    cfg_we = 1; cfg_wdata = d; e_valid = 1; e_chan = 0; e_amt = 50;
    #1;
    chk(e_ready == mlock, "R8 ready", e_ready, mlock);
    @(negedge clk);
    cfg_we = 0; e_valid = 0;
    if (!mlock) begin
      mreg = d; mlock = d[REG_W-1];
      for (int k = 0; k < 2; k++) begin
        mpwr[k] = d[k*22 +: 14]; mx[k] = d[k*22+14 +: 2];
        my[k] = d[k*22+16 +: 5]; men[k] = d[k*22+21];
      end
      hist.delete(); macc = '{0, 0}; mlast = '{0, 0}; mthr = 0; mchthr = 0;
      chk(throttle == 0 && chan_thr == 0, "R9 clear", throttle, 0);
    end else begin
      macc[0] += 50;
    end
    chk(cfg_rdata == mreg, "R4 rdata", cfg_rdata, mreg);
  endtask

  task automatic slot(int e0, int e1, string req);
    bit prev = mthr;
    e_valid = 1; e_chan = 0; e_amt = e0[7:0];
    @(negedge clk);
    chk(throttle == prev, "R7 hold", throttle, prev);
    e_chan = 1; e_amt = e1[7:0]; tick = 1;
    mdur = (mdur + mchthr[0] + mchthr[1]) % 64;
    @(negedge clk);
    e_valid = 0; tick = 0;
    macc[0] += e0; macc[1] += e1;
    hist.push_back(macc[0] + macc[1]);
    mlast = macc; macc = '{0, 0};
    evaluate();
    chk(throttle == mthr, req, throttle, mthr);
    chk(chan_thr == mchthr, "R5 chan_thr", chan_thr, mchthr);
    chk(thr_dur == DUR_W'(mdur), "R6 dur", thr_dur, mdur);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mreg = '0; mlock = 0; mdur = 0; mthr = 0; mchthr = 0;
    men = '{0, 0}; hist.delete(); macc = '{0, 0}; mlast = '{0, 0};
    chk(throttle == 0, "R10 throttle", throttle, 0);
    chk(chan_thr == 0, "R10 chan_thr", chan_thr, 0);
    chk(thr_dur == 0, "R10 dur", thr_dur, 0);
    chk(cfg_rdata == 0, "R10 rdata", cfg_rdata, 0);
    chk(e_ready == 1, "R10 ready", e_ready, 1);
  endtask

  initial begin
    mfloor = '{0, 0};
    @(negedge clk);
    do_reset();

    // R1 / R2: window sweep over every fraction and exponent 0..4
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 5; y++) begin
        wr_cfg({1'b0, lim_word(0, 0, 0, 0), lim_word(1, 10, x, y)});
        for (int i = 0; i < 12; i++)
          slot((i*5 + x*3 + y) % 17, (i*3) % 9, "R1 window");
      end

    // R2: equality does not throttle, one step more does
    wr_cfg({1'b0, lim_word(0, 0, 0, 0), lim_word(1, 6, 0, 2)});
    for (int i = 0; i < 5; i++) slot(3, 3, "R2 equal");
    slot(4, 3, "R2 over");

    // R3: disabled cap ignored, enabled cap in the other slot acts
    wr_cfg({1'b0, lim_word(1, 20, 1, 1), lim_word(0, 3, 0, 0)});
    for (int i = 0; i < 10; i++) slot((i*7) % 23, (i*4) % 19, "R3 two caps");
    wr_cfg({1'b0, lim_word(1, 20, 1, 3), lim_word(1, 9, 2, 0)});
    for (int i = 0; i < 10; i++) slot((i*11) % 21, (i*2) % 7, "R3 both");

    // R5: floors spare the quiet channel
    mfloor = '{5, 30}; floor_q = {8'd30, 8'd5};
    wr_cfg({1'b0, lim_word(0, 0, 0, 0), lim_word(1, 2, 0, 0)});
    for (int i = 0; i < 12; i++) slot((i*3) % 11, (i*9) % 40, "R5 floor");

    // R6: both channels throttled every tick, counter wraps
    mfloor = '{0, 0}; floor_q = '0;
    wr_cfg({1'b0, lim_word(0, 0, 0, 0), lim_word(1, 0, 0, 0)});
    for (int i = 0; i < 40; i++) slot(1, 1, "R6 wrap");

    // R4: lock, then a refused write
    wr_cfg({1'b1, lim_word(0, 0, 0, 0), lim_word(1, 4, 0, 1)});
    slot(3, 3, "R4 locked cfg");
    wr_cfg({1'b0, lim_word(0, 0, 0, 0), lim_word(1, 100, 0, 0)});
    for (int i = 0; i < 4; i++) slot(2, 1, "R4 locked cfg");

    do_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule